// File: doc/BRIEF.md
# Noise-Shaped Truncated-Phase Sine Synthesizer

This block is a direct digital synthesizer that turns a programmable frequency word into a stream of signed sine amplitude samples for a DAC. A wide phase accumulator adds the frequency word on every enabled clock. The frequency step is therefore the clock rate divided by two to the power of the accumulator width. Only a short slice at the top of the phase addresses a sine table, which keeps the table small.

Cutting the phase down to a short address would normally leave a periodic truncation error, and that error shows up as spurs in the output. Here the discarded low phase bits feed a cascade of first-order accumulators. The cascade is built from adders only, with no multipliers. Their carries are recombined into a small signed correction that is added to the truncated phase before the lookup. This pushes the truncation error towards high frequencies, where a deglitch filter after the DAC can remove it. The scheme relies on oversampling: the synthesized tone must stay well below the clock rate.

The sine table is computed at elaboration time from the parameters. The cascade order is a parameter from 1 to 4.

Top module: `shaped_dds`

## Requirements
- R1: While the synchronous reset `rst` is high, the phase accumulator, all shaper stage registers and delay registers, the address register and the output register are cleared. After reset, `amp_o` is 0 and stays 0 for as long as `en` is low.
- R2: On each rising clock edge with `en` high and `rst` low, the phase becomes (phase + `fword_i`) mod 2^ACC_W. A new `fword_i` value is used at the very next enabled edge.
- R3: The table address is (top ADDR_W bits of the phase + correction) mod 2^ADDR_W. It is captured in an address register on each enabled edge. The correction is a two's-complement value.
- R4: The low FRAC_W = ACC_W-ADDR_W phase bits feed ORDER cascaded first-order accumulators, each FRAC_W bits wide. Stage 1 adds the low phase bits. Each later stage adds the new value of the stage before it. Stage k yields a carry c_k. The correction is the sum over k of (1 - z^-1)^(k-1) applied to c_k, built from adders and delay registers only. All delay states start at zero.
- R5: The table entry at address a is round((2^(AMP_W-1)-1) * sin(2*pi*a / 2^ADDR_W)), in two's complement.
- R6: `amp_o` is registered from the table at the address register's value. A phase value therefore reaches the output two enabled edges after it is present in the accumulator.
- R7: With `en` low, no state changes, and `amp_o` keeps its value.
- R8: With `fword_i` = 0 from reset and `en` high, `amp_o` stays 0.
- R9: With `fword_i` = 2^(ACC_W-2) from reset, `amp_o` on successive enabled edges reads 0, 0, +max, 0, -max, 0, +max, 0, where max = 2^(AMP_W-1)-1. With `fword_i` = 2^(ACC_W-1) from reset, `amp_o` is 0 on every cycle.
- R10: The correction always lies in the range -(2^(ORDER-1)-1) to 2^(ORDER-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes all state |
| fword_i | input | ACC_W | Frequency word added to the phase each enabled clock |
| amp_o | output | AMP_W | Signed sine amplitude sample for the DAC |

## Verification
A zero word and the half-scale word leave the low phase bits at zero, so no correction ever appears. These two words show that the accumulator and the table path are free of spurious dither. The quarter-scale word walks the four cardinal table points and pins down the table scaling, sign and two-edge latency exactly. Words with busy low bits are compared edge by edge against a model that recombines carry histories with binomial weights. Such words include a slow fraction-only rate, a half-step rate, an almost-Nyquist rate and irregular patterns. Only a correct cascade, carry recombination and address wrap can match that model. Enable gaps, word changes mid-run and a reset while running separate correct hold and restart behaviour from state that leaks across a pause.

// File: rtl/shaped_dds_pkg.sv
package shaped_dds_pkg;

  // pi/2 scaled by 2^30
  localparam longint HALF_PI_Q30 = 64'sd1686629713;

  // Sine table entry: round(max * sin(2*pi*idx / 2^aw)) using quarter-wave
  // folding and an integer Taylor series evaluated in Q30.
  function automatic int sine_word(input int idx, input int aw, input int ampw);
    longint quarter;
    longint q;
    longint x;
    longint x2;
    longint term;
    longint sum;
    longint ampl;
    longint r;
    int     quad;
    bit     neg;
    quarter = longint'(1) << (aw - 2);
    quad    = (idx >> (aw - 2)) & 3;
    q       = longint'(idx) & (quarter - 1);
    if (quad == 1 || quad == 3) q = quarter - q;
    neg  = (quad >= 2);
    x    = (HALF_PI_Q30 * q) / quarter;
    x2   = (x * x) >>> 30;
    term = x;
    sum  = x;
    for (int k = 1; k <= 7; k++) begin
      term = (term * x2) >>> 30;
      term = -term / longint'((2 * k) * (2 * k + 1));
      sum  = sum + term;
    end
    ampl = (longint'(1) << (ampw - 1)) - 1;
    r    = (sum * ampl + (longint'(1) << 29)) >>> 30;
    return neg ? -int'(r) : int'(r);
  endfunction

endpackage

// File: rtl/sdds_phase_acc.sv
module sdds_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] fword_i,
  output logic [ACC_W-1:0] phase_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_q + fword_i;
  end

  assign phase_o = acc_q;
endmodule

// File: rtl/sdds_mash.sv
module sdds_mash #(
  parameter int FRAC_W = 24,
  parameter int ORDER  = 4,
  parameter int CORR_W = ORDER + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [FRAC_W-1:0]        frac_i,
  output logic signed [CORR_W-1:0] corr_o
);
  logic [FRAC_W-1:0]        st_q   [ORDER];
  logic [FRAC_W-1:0]        nxt_w  [ORDER];
  logic [ORDER-1:0]         carry_w;
  logic signed [CORR_W-1:0] y_w    [ORDER+1];
  logic signed [CORR_W-1:0] hist_q [ORDER];

  assign y_w[ORDER] = '0;

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    logic [FRAC_W:0] tot_w;
    if (k == 0) begin : g_first
      assign tot_w = {1'b0, st_q[k]} + {1'b0, frac_i};
    end else begin : g_next
      assign tot_w = {1'b0, st_q[k]} + {1'b0, nxt_w[k-1]};
    end
    assign nxt_w[k]   = tot_w[FRAC_W-1:0];
    assign carry_w[k] = tot_w[FRAC_W];

    // recombination: carry plus first difference of the deeper stage's output
    assign y_w[k] = signed'({{(CORR_W-1){1'b0}}, carry_w[k]}) + y_w[k+1] - hist_q[k];

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[k]   <= '0;
        hist_q[k] <= '0;
      end else if (en) begin
        st_q[k]   <= nxt_w[k];
        hist_q[k] <= y_w[k+1];
      end
    end
  end

  assign corr_o = y_w[0];
endmodule

// File: rtl/sdds_sine_rom.sv
module sdds_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic signed [AMP_W-1:0] amp_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic signed [AMP_W-1:0] tbl_w [DEPTH];
  logic signed [AMP_W-1:0] amp_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
    localparam int VAL = shaped_dds_pkg::sine_word(i, ADDR_W, AMP_W);
    assign tbl_w[i] = VAL[AMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     amp_q <= '0;
    else if (en) amp_q <= tbl_w[addr_i];
  end

  assign amp_o = amp_q;
endmodule

// File: rtl/shaped_dds.sv
module shaped_dds #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 10,
  parameter int ORDER  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        fword_i,
  output logic signed [AMP_W-1:0] amp_o
);
  localparam int FRAC_W = ACC_W - ADDR_W;
  localparam int CORR_W = ORDER + 1;

  logic [ACC_W-1:0]         phase_w;
  logic [ADDR_W-1:0]        trunc_w;
  logic [FRAC_W-1:0]        frac_w;
  logic signed [CORR_W-1:0] corr_w;
  logic [ADDR_W-1:0]        corr_ext_w;
  logic [ADDR_W-1:0]        addr_q;

  sdds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .en(en), .fword_i(fword_i), .phase_o(phase_w)
  );

  assign trunc_w = phase_w[ACC_W-1 -: ADDR_W];
  assign frac_w  = phase_w[FRAC_W-1:0];

  sdds_mash #(.FRAC_W(FRAC_W), .ORDER(ORDER), .CORR_W(CORR_W)) u_shaper (
    .clk(clk), .rst(rst), .en(en), .frac_i(frac_w), .corr_o(corr_w)
  );

  assign corr_ext_w = ADDR_W'(corr_w);

  always_ff @(posedge clk) begin
    if (rst)     addr_q <= '0;
    else if (en) addr_q <= trunc_w + corr_ext_w;
  end

  sdds_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
    .clk(clk), .rst(rst), .en(en), .addr_i(addr_q), .amp_o(amp_o)
  );
endmodule

// File: rtl/shaped_dds_chk.sv
module shaped_dds_chk #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 10,
  parameter int ORDER  = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       en,
  input logic [ACC_W-1:0]           phase,
  input logic [ACC_W-1:0]           fword,
  input logic signed [ORDER:0]      corr,
  input logic [ADDR_W-1:0]          addr,
  input logic signed [AMP_W-1:0]    amp
);
  localparam int CORR_HI = 1 << (ORDER - 1);
  localparam int CORR_LO = 1 - CORR_HI;

  // R1: a reset edge leaves phase, address and output at zero
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (phase == '0 && addr == '0 && amp == '0));

  // R2: phase steps by the word seen at the enabled edge
  a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
    en |=> phase == $past(ACC_W'(phase + fword)));

  // R3: captured address is truncated phase plus correction, wrapped
  a_r3_addr_wrap: assert property (@(posedge clk) disable iff (rst)
    en |=> addr == $past(ADDR_W'(phase[ACC_W-1 -: ADDR_W] + ADDR_W'(corr))));

  // R7: disabled clock freezes phase, address and output
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(phase) && $stable(addr) && $stable(amp)));

  // R10: correction bounded by the cascade order
  a_r10_corr_range: assert property (@(posedge clk) disable iff (rst)
    (corr <= CORR_HI) && (corr >= CORR_LO));
endmodule

bind shaped_dds shaped_dds_chk #(
  .ACC_W(ACC_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W), .ORDER(ORDER)
) chk_i (
  .clk(clk), .rst(rst), .en(en), .phase(phase_w), .fword(fword_i),
  .corr(corr_w), .addr(addr_q), .amp(amp_o)
);

// File: tb/shaped_dds_tb_top.sv
`timescale 1ns/1ps
module shaped_dds_tb_top;
  localparam int ACC_W  = 32;
  localparam int ADDR_W = 8;
  localparam int AMP_W  = 10;
  localparam int ORDER  = 4;
  localparam int FRAC_W = ACC_W - ADDR_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int MAXA   = (1 << (AMP_W - 1)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [ACC_W-1:0] fw = '0;
  logic signed [AMP_W-1:0] amp;

  int vectors = 0;
  int fails   = 0;
  bit cmp_on  = 1'b0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  shaped_dds #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W), .ORDER(ORDER)) dut_i (
    .clk(clk), .rst(rst), .en(en), .fword_i(fw), .amp_o(amp)
  );

  // ---------------- reference model ----------------
  int     tbl [DEPTH];
  longint m_acc;
  longint m_st [ORDER];
  int     chist [ORDER][ORDER];
  int     m_addr;
  int     m_amp;

  function automatic int binom(input int n, input int r);
    int v = 1;
    for (int i = 0; i < r; i++) v = v * (n - i) / (i + 1);
    return v;
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      real v;
      v = real'(MAXA) * $sin(2.0 * 3.14159265358979323846 * real'(i) / real'(DEPTH));
      tbl[i] = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_addr = 0; m_amp = 0;
      for (int k = 0; k < ORDER; k++) begin
        m_st[k] = 0;
        for (int j = 0; j < ORDER; j++) chist[k][j] = 0;
      end
    end else if (en) begin
      longint fmask;
      longint inp;
      longint t;
      int     c [ORDER];
      int     d;
      int     trunc;
      fmask = (longint'(1) << FRAC_W) - 1;
      inp   = m_acc & fmask;
      trunc = int'(m_acc >> FRAC_W);
      for (int k = 0; k < ORDER; k++) begin
        t       = m_st[k] + inp;
        c[k]    = int'(t >> FRAC_W);
        m_st[k] = t & fmask;
        inp     = m_st[k];
      end
      d = 0;
      for (int k = 0; k < ORDER; k++)
        for (int j = 0; j <= k; j++)
          d += binom(k, j) * ((j % 2) ? -1 : 1) * ((j == 0) ? c[k] : chist[k][j-1]);
      for (int k = 0; k < ORDER; k++) begin
        for (int j = ORDER - 1; j > 0; j--) chist[k][j] = chist[k][j-1];
        chist[k][0] = c[k];
      end
      m_amp  = tbl[m_addr];
      m_addr = (trunc + d) & (DEPTH - 1);
      m_acc  = (m_acc + longint'(fw)) & ((longint'(1) << ACC_W) - 1);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: amp_o=%0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model (R2 R3 R4 R5 R6)
  always @(negedge clk) begin
    if (cmp_on) check("R2 R3 R4 R5 R6 model", int'(amp), m_amp);
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_word(input logic [ACC_W-1:0] w, input int n);
    fw = w; en = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int seq [8];
    int prev;
    seq = '{0, 0, MAXA, 0, -MAXA, 0, MAXA, 0};

    // R1: reset state and idle after reset
    repeat (3) @(negedge clk);
    check("R1 in reset", int'(amp), 0);
    rst = 1'b0; fw = 32'h1234_5678; en = 1'b0;
    cmp_on = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 idle after reset", int'(amp), 0);
    end

    // R8: zero word stays at zero
    do_reset(); rst = 1'b0; fw = '0; en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R8 zero word", int'(amp), 0);
    end

    // R9: quarter-scale word walks cardinal points
    do_reset(); rst = 1'b0; fw = 32'h4000_0000; en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R9 quarter word", int'(amp), seq[i]);
    end

    // R9: half-scale word stays at zero
    do_reset(); rst = 1'b0; fw = 32'h8000_0000; en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check("R9 half word", int'(amp), 0);
    end

    // R4 R10: busy low bits, word changes without reset (R2)
    do_reset(); rst = 1'b0;
    run_word(32'h0123_4567, 300);
    run_word(32'h0000_0101, 300);
    run_word(32'h0080_0000, 300);
    run_word(32'h7FFF_FFFF, 300);
    run_word(32'h3333_3333, 300);
    run_word(32'hF0E1_D2C3, 300);

    // R7: enable gaps hold the output
    fw = 32'h0765_4321;
    prev = int'(amp);
    for (int i = 0; i < 240; i++) begin
      en = (i % 3) != 0;
      @(negedge clk);
      if (!en) check("R7 hold", int'(amp), prev);
      prev = int'(amp);
    end

    // R1: reset while running
    en = 1'b1;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset while running", int'(amp), 0);
    rst = 1'b0; en = 1'b0;
    @(negedge clk);
    check("R1 reset while running idle", int'(amp), 0);
    run_word(32'h0009_9999, 400);

    cmp_on = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run not finished, actual cycles 150000 expected fewer");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule